// File: doc/BRIEF.md
# Pipelined Burst SRAM Front-End

This block is a synchronous single-port static memory with a registered bus front-end. The default array holds 256 words of 36 bits, split into four 9-bit byte lanes. Every control, address and data input is captured on the rising clock edge. In the following cycle the captured set is classified as a deselect, a burst start from the processor strobe, a burst start from the controller strobe, a burst continue or a burst suspend. The array is then written, or read into a one-stage output register.

A burst start loads the full word address. In a continue cycle, the two low address bits come from an external burst sequencer through a dedicated input. The upper bits stay those of the burst start. A suspend cycle repeats the current address. Read data is presented on a separate output port with a valid flag, and an asynchronous active-low output enable can blank both at any time. A deselect clears the burst, so that later continue or suspend cycles perform no access.

Top module: `pipeburst_sram`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rvalid_o` is 0 and `rdata_o` is all zeros.
- R2: A read whose inputs are captured at clock edge N drives `rvalid_o`=1 and the addressed word on `rdata_o` after edge N+1, and holds them until edge N+2.
- R3: Write decode, with lane i covering data bits [9i+8:9i] and `lane_n_i[i]` as its active-low strobe. `wr_all_n_i`=0 writes all four lanes, whatever the other write inputs are. With `wr_all_n_i`=1 and `lane_en_n_i`=0, each lane whose strobe is 0 is written. `lane_en_n_i`=1, or all strobes at 1, makes the cycle a read.
- R4: With `sel_n_i`=1, the processor strobe is ignored and the cycle behaves as a continue or suspend. The controller strobe with `sel_n_i`=1 is a deselect.
- R5: A burst started by the processor strobe, with all enables active, is a read and leaves the array unchanged, whatever the write inputs are. When both strobes are low with the enables active, the processor strobe wins.
- R6: A burst started by the controller strobe, with the processor strobe high and all enables active, reads or writes according to the R3 decode.
- R7: The secondary enables (`sel_hi_i` active high, `sel_lo_n_i` active low) are looked at only in strobe cycles. If either is inactive on a strobe, the cycle is a deselect. In continue and suspend cycles they have no effect.
- R8: With both strobes high, `step_n_i`=0 accesses the word whose upper bits come from the burst start and whose low two bits come from `burst_lo_i`. `step_n_i`=1 repeats the current word.
- R9: `out_en_n_i`=1 forces `rvalid_o` to 0 and `rdata_o` to zero, with no clock edge needed. Returning it to 0 shows the held read word again.
- R10: A deselect captured at edge N leaves `rvalid_o`=0 after edge N+1.
- R11: After a deselect, continue and suspend cycles neither read nor write the array until a new burst start.
- R12: A write cycle captured at edge N leaves `rvalid_o`=0 after edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address, used on burst starts |
| burst_lo_i | input | 2 | Low two address bits from the external burst sequencer, used in continue cycles |
| sel_n_i | input | 1 | Primary chip enable, active low; also masks the processor strobe |
| sel_hi_i | input | 1 | Secondary chip enable, active high |
| sel_lo_n_i | input | 1 | Secondary chip enable, active low |
| start_cpu_n_i | input | 1 | Processor address strobe, active low, higher priority |
| start_ctl_n_i | input | 1 | Controller address strobe, active low |
| step_n_i | input | 1 | Burst advance, active low; high suspends |
| wr_all_n_i | input | 1 | Global write, active low |
| lane_en_n_i | input | 1 | Byte-write enable, active low |
| lane_n_i | input | LANES | Per-lane write strobes, active low |
| wdata_i | input | LANES*LANE_W | Write data |
| out_en_n_i | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | LANES*LANE_W | Read data, zero when not valid |
| rvalid_o | output | 1 | Read data valid |

## Verification
The two functions that can land in one cycle are the two strobes. When both are low, processor priority has to override the write inputs. The bench drives both strobes low with global write active on a word of known contents, then checks that the returned data is the old word and that a second read still finds it unchanged. A related collision is a masked processor strobe, driven with global write active while the primary enable is off after a deselect. It is judged the same way: no output appears and the word is still intact on a later read.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [2:0] {
    K_DESEL   = 3'd0,
    K_BEGIN_P = 3'd1,
    K_BEGIN_C = 3'd2,
    K_CONT    = 3'd3,
    K_SUSP    = 3'd4
  } kind_e;

  // captured controls, all converted to active-high meaning
  typedef struct packed {
    logic cpu;
    logic ctl;
    logic hold;
    logic sel_main;
    logic sel_aux;
    logic wall;
    logic lane_en;
  } ctrl_t;
endpackage

// File: rtl/sram_fe_capture.sv
module sram_fe_capture #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int DATA_W = 36
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [1:0]          lo_i,
  input  logic                sel_n_i,
  input  logic                sel_hi_i,
  input  logic                sel_lo_n_i,
  input  logic                cpu_n_i,
  input  logic                ctl_n_i,
  input  logic                step_n_i,
  input  logic                wall_n_i,
  input  logic                lane_en_n_i,
  input  logic [LANES-1:0]    lane_n_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output psram_pkg::ctrl_t    ctrl_q,
  output logic [ADDR_W-1:0]   addr_q,
  output logic [1:0]          lo_q,
  output logic [LANES-1:0]    lane_q,
  output logic [DATA_W-1:0]   wdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      addr_q  <= '0;
      lo_q    <= '0;
      lane_q  <= '0;
      wdata_q <= '0;
    end else begin
      ctrl_q.cpu      <= ~cpu_n_i;
      ctrl_q.ctl      <= ~ctl_n_i;
      ctrl_q.hold     <= step_n_i;
      ctrl_q.sel_main <= ~sel_n_i;
      ctrl_q.sel_aux  <= sel_hi_i & ~sel_lo_n_i;
      ctrl_q.wall     <= ~wall_n_i;
      ctrl_q.lane_en  <= ~lane_en_n_i;
      addr_q  <= addr_i;
      lo_q    <= lo_i;
      lane_q  <= ~lane_n_i;
      wdata_q <= wdata_i;
    end
  end
endmodule

// File: rtl/sram_fe_decode.sv
module sram_fe_decode #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  psram_pkg::ctrl_t    ctrl,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [1:0]          lo,
  input  logic [LANES-1:0]    lane,
  output psram_pkg::kind_e    kind,
  output logic                acc_rd,
  output logic                acc_wr,
  output logic [ADDR_W-1:0]   acc_addr,
  output logic [LANES-1:0]    lane_we,
  output logic                burst_live
);
  import psram_pkg::*;
  localparam int UP_W = ADDR_W - 2;

  // lanes selected by the write controls; zero means the cycle reads
  function automatic logic [LANES-1:0] lane_mask(input logic wall,
                                                 input logic lane_en,
                                                 input logic [LANES-1:0] sel);
    if (wall)    return '1;
    if (lane_en) return sel;
    return '0;
  endfunction

  logic [UP_W-1:0] base_q;
  logic [1:0]      cur_lo_q;
  logic            live_q;
  logic [LANES-1:0] wmask;
  logic            cpu_eff;

  assign wmask      = lane_mask(ctrl.wall, ctrl.lane_en, lane);
  assign cpu_eff    = ctrl.cpu & ctrl.sel_main;
  assign burst_live = live_q;

  always_comb begin
    if (cpu_eff)       kind = ctrl.sel_aux ? K_BEGIN_P : K_DESEL;
    else if (ctrl.ctl) kind = (ctrl.sel_main & ctrl.sel_aux) ? K_BEGIN_C : K_DESEL;
    else               kind = ctrl.hold ? K_SUSP : K_CONT;
  end

  always_comb begin
    acc_rd   = 1'b0;
    acc_wr   = 1'b0;
    acc_addr = addr;
    unique case (kind)
      K_BEGIN_P: acc_rd = 1'b1;
      K_BEGIN_C: begin
        acc_wr = |wmask;
        acc_rd = ~|wmask;
      end
      K_CONT: begin
        acc_addr = {base_q, lo};
        acc_wr   = live_q & (|wmask);
        acc_rd   = live_q & ~|wmask;
      end
      K_SUSP: begin
        acc_addr = {base_q, cur_lo_q};
        acc_wr   = live_q & (|wmask);
        acc_rd   = live_q & ~|wmask;
      end
      default: ;
    endcase
  end

  assign lane_we = acc_wr ? wmask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q   <= 1'b0;
      base_q   <= '0;
      cur_lo_q <= '0;
    end else begin
      unique case (kind)
        K_DESEL: live_q <= 1'b0;
        K_BEGIN_P, K_BEGIN_C: begin
          live_q   <= 1'b1;
          base_q   <= addr[ADDR_W-1:2];
          cur_lo_q <= addr[1:0];
        end
        K_CONT: if (live_q) cur_lo_q <= lo;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sram_fe_array.sv
module sram_fe_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES-1:0]          lane_we,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rword
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rword[g*LANE_W +: LANE_W] = mem[addr];
  end
endmodule

// File: rtl/sram_fe_outreg.sv
module sram_fe_outreg #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] rword,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] dout_q;
  logic              valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= load;
      if (load) dout_q <= rword;
    end
  end

  assign rvalid = valid_q & ~out_en_n;
  assign rdata  = rvalid ? dout_q : '0;
endmodule

// File: rtl/pipeburst_sram.sv
module pipeburst_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [1:0]               burst_lo_i,
  input  logic                     sel_n_i,
  input  logic                     sel_hi_i,
  input  logic                     sel_lo_n_i,
  input  logic                     start_cpu_n_i,
  input  logic                     start_ctl_n_i,
  input  logic                     step_n_i,
  input  logic                     wr_all_n_i,
  input  logic                     lane_en_n_i,
  input  logic [LANES-1:0]         lane_n_i,
  input  logic [LANES*LANE_W-1:0]  wdata_i,
  input  logic                     out_en_n_i,
  output logic [LANES*LANE_W-1:0]  rdata_o,
  output logic                     rvalid_o
);
  import psram_pkg::*;
  localparam int DATA_W = LANES * LANE_W;

  ctrl_t             ctrl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        lo_q;
  logic [LANES-1:0]  lane_q;
  logic [DATA_W-1:0] wdata_q;

  // named internal events, observed by the bound checker
  kind_e             kind;
  logic              acc_rd;
  logic              acc_wr;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  lane_we;
  logic              burst_live;
  logic              cap_wall;
  logic [DATA_W-1:0] rword;

  assign cap_wall = ctrl_q.wall;

  sram_fe_capture #(.ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .lo_i(burst_lo_i),
    .sel_n_i(sel_n_i), .sel_hi_i(sel_hi_i), .sel_lo_n_i(sel_lo_n_i),
    .cpu_n_i(start_cpu_n_i), .ctl_n_i(start_ctl_n_i), .step_n_i(step_n_i),
    .wall_n_i(wr_all_n_i), .lane_en_n_i(lane_en_n_i), .lane_n_i(lane_n_i),
    .wdata_i(wdata_i), .ctrl_q(ctrl_q), .addr_q(addr_q), .lo_q(lo_q),
    .lane_q(lane_q), .wdata_q(wdata_q)
  );

  sram_fe_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .addr(addr_q), .lo(lo_q),
    .lane(lane_q), .kind(kind), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .lane_we(lane_we), .burst_live(burst_live)
  );

  sram_fe_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .addr(acc_addr), .lane_we(lane_we), .wdata(wdata_q), .rword(rword)
  );

  sram_fe_outreg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(acc_rd), .rword(rword),
    .out_en_n(out_en_n_i), .rdata(rdata_o), .rvalid(rvalid_o)
  );
endmodule

// File: rtl/pipeburst_sram_chk.sv
module pipeburst_sram_chk #(
  parameter int LANES  = 4,
  parameter int DATA_W = 36
) (
  input logic                 clk,
  input logic                 rst_n,
  input psram_pkg::kind_e     kind,
  input logic                 acc_rd,
  input logic                 acc_wr,
  input logic [LANES-1:0]     lane_we,
  input logic                 cap_wall,
  input logic                 burst_live,
  input logic                 out_en_n_i,
  input logic                 rvalid_o,
  input logic [DATA_W-1:0]    rdata_o
);
  import psram_pkg::*;

  // R5
  begin_p_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kind == K_BEGIN_P |-> acc_rd && lane_we == '0);

  // R10
  desel_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kind == K_DESEL |=> !rvalid_o);

  // R2
  read_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> (rvalid_o || out_en_n_i));

  // R12
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> !rvalid_o);

  // R9
  oe_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n_i |-> !rvalid_o && rdata_o == '0);

  // R3
  global_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr && cap_wall |-> $countones(lane_we) == LANES);

  // R11
  idle_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_CONT || kind == K_SUSP) && !burst_live |-> !acc_rd && !acc_wr);

  // R6
  rd_wr_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_rd && acc_wr));
endmodule

bind pipeburst_sram pipeburst_sram_chk #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .kind(kind), .acc_rd(acc_rd), .acc_wr(acc_wr),
  .lane_we(lane_we), .cap_wall(cap_wall), .burst_live(burst_live),
  .out_en_n_i(out_en_n_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o)
);

// File: tb/pipeburst_sram_test.sv
`timescale 1ns/100ps
module pipeburst_sram_test;
  localparam int AW = 8;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic [1:0] lo;
  logic sel_n, sel_hi, sel_lo_n, cpu_n, ctl_n, step_n, wall_n, len_n, oe_n;
  logic [NL-1:0] lane_n;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic rvalid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [DW-1:0] model [256];

  always #2.5 clk = ~clk;

  pipeburst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .burst_lo_i(lo),
    .sel_n_i(sel_n), .sel_hi_i(sel_hi), .sel_lo_n_i(sel_lo_n),
    .start_cpu_n_i(cpu_n), .start_ctl_n_i(ctl_n), .step_n_i(step_n),
    .wr_all_n_i(wall_n), .lane_en_n_i(len_n), .lane_n_i(lane_n),
    .wdata_i(wdata), .out_en_n_i(oe_n), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  // vector: addr[49:42] wall_n[41] len_n[40] lane_n[39:36] data[35:0]
  localparam logic [49:0] VEC [8] = '{
    {8'h20, 1'b0, 1'b1, 4'b1111, 36'h1_2345_6789},
    {8'h21, 1'b1, 1'b0, 4'b1110, 36'h0_0000_01AB},
    {8'h22, 1'b1, 1'b0, 4'b0101, 36'hF_0F0F_0F0F},
    {8'h23, 1'b1, 1'b1, 4'b0000, 36'hA_AAAA_AAAA},
    {8'h24, 1'b1, 1'b0, 4'b1111, 36'h5_5555_5555},
    {8'h25, 1'b0, 1'b0, 4'b0000, 36'h9_8765_4321},
    {8'h26, 1'b1, 1'b0, 4'b0111, 36'hE_DC00_0000},
    {8'h27, 1'b0, 1'b1, 4'b1010, 36'h0_1357_9BDF}
  };

  function automatic logic [DW-1:0] fill(input logic [7:0] a);
    return {4{1'b1, a}};
  endfunction

  // bench restatement of the byte-write rule
  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic g_n,
                                          input logic e_n, input logic [NL-1:0] l_n,
                                          input logic [DW-1:0] d);
    logic [DW-1:0] r;
    r = old;
    for (int i = 0; i < NL; i++)
      if (!g_n || (!e_n && !l_n[i])) r[i*LW +: LW] = d[i*LW +: LW];
    return r;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic quiet_wr();
    wall_n = 1'b1; len_n = 1'b1; lane_n = '1; wdata = '0;
  endtask

  task automatic drv_desel();
    sel_n = 1'b1; sel_hi = 1'b1; sel_lo_n = 1'b0;
    cpu_n = 1'b1; ctl_n = 1'b0; step_n = 1'b1; lo = 2'd0;
    quiet_wr();
  endtask

  task automatic drv_ctl(input logic [7:0] a, input logic g_n, input logic e_n,
                         input logic [NL-1:0] l_n, input logic [DW-1:0] d);
    sel_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
    cpu_n = 1'b1; ctl_n = 1'b0; step_n = 1'b1; addr = a;
    wall_n = g_n; len_n = e_n; lane_n = l_n; wdata = d;
    model[a] = merge(model[a], g_n, e_n, l_n, d);
  endtask

  task automatic drv_cpu(input logic [7:0] a);
    sel_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
    cpu_n = 1'b0; ctl_n = 1'b1; step_n = 1'b1; addr = a;
    quiet_wr();
  endtask

  task automatic drv_cont(input logic s_n, input logic [1:0] l);
    sel_n = 1'b1; sel_hi = 1'b0; sel_lo_n = 1'b1;
    cpu_n = 1'b1; ctl_n = 1'b1; step_n = s_n; lo = l;
    quiet_wr();
  endtask

  task automatic chk(input string tag, input logic ev, input logic [DW-1:0] ed);
    checks++;
    if (rvalid !== ev || rdata !== ed) begin
      fails++;
      $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               tag, rvalid, rdata, ev, ed);
    end
  endtask

  task automatic read_chk(input string tag, input logic [7:0] a);
    drv_cpu(a); tick(); drv_desel(); tick();
    chk(tag, 1'b1, model[a]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; oe_n = 1'b0; addr = '0;
    drv_desel();
    tick(); tick();
    chk("R1 in reset", 1'b0, '0);
    rst_n = 1'b1; tick();
    chk("R1 after reset", 1'b0, '0);

    // prefill table words and scratch words with global writes
    for (int i = 0; i < 8; i++) begin
      drv_ctl(8'h20 + 8'(i), 1'b0, 1'b1, '1, fill(8'h20 + 8'(i))); tick();
    end
    for (int i = 0; i < 4; i++) begin
      drv_ctl(8'h40 + 8'(i), 1'b0, 1'b1, '1, fill(8'h40 + 8'(i))); tick();
    end
    drv_ctl(8'h10, 1'b0, 1'b1, '1, fill(8'h10)); tick();
    drv_ctl(8'h11, 1'b0, 1'b1, '1, fill(8'h11)); tick();
    drv_desel(); tick();
    chk("R12 writes give no output", 1'b0, '0);

    // table walk: R3 / R6 write decode through the controller strobe
    for (int i = 0; i < 8; i++) begin
      logic [49:0] v;
      v = VEC[i];
      drv_ctl(v[49:42], v[41], v[40], v[39:36], v[35:0]); tick();
      drv_cpu(v[49:42]); tick();
      drv_desel(); tick();
      chk("R3 R6 lane decode", 1'b1, model[v[49:42]]);
    end

    // R5: processor strobe with global write active stays a read
    drv_cpu(8'h10); wall_n = 1'b0; len_n = 1'b0; lane_n = '0; wdata = '1; tick();
    drv_desel(); tick();
    chk("R5 cpu start reads", 1'b1, fill(8'h10));
    read_chk("R5 word untouched", 8'h10);

    // R5: both strobes low with write controls, processor wins
    drv_cpu(8'h10); ctl_n = 1'b0; wall_n = 1'b0; wdata = '1; tick();
    drv_desel(); tick();
    chk("R5 priority read", 1'b1, fill(8'h10));
    read_chk("R5 priority no write", 8'h10);

    // R4: masked processor strobe after deselect does nothing
    sel_n = 1'b1; cpu_n = 1'b0; ctl_n = 1'b1; step_n = 1'b0; addr = 8'h10;
    wall_n = 1'b0; wdata = '1; tick();
    drv_desel(); tick();
    chk("R4 masked cpu strobe", 1'b0, '0);
    read_chk("R4 masked no write", 8'h10);

    // R4 / R10: controller strobe with primary enable off deselects mid-burst
    drv_cpu(8'h11); tick();
    drv_desel(); tick();
    chk("R4 read before deselect", 1'b1, fill(8'h11));
    drv_cont(1'b0, 2'd2); tick();
    chk("R10 single-cycle deselect", 1'b0, '0);

    // R7: secondary enables off on a strobe deselect, no write
    drv_ctl(8'h10, 1'b1, 1'b1, '1, '0);
    sel_hi = 1'b0; wall_n = 1'b0; wdata = '1; tick();
    drv_desel(); tick();
    chk("R7 aux enable off deselects", 1'b0, '0);
    drv_cpu(8'h10); sel_lo_n = 1'b1; tick();
    drv_desel(); tick();
    chk("R7 low aux enable off deselects", 1'b0, '0);
    read_chk("R7 no write", 8'h10);

    // R8 / R7 / R9: read burst with continue, suspend and external low bits
    drv_cpu(8'h41); tick();
    drv_cont(1'b0, 2'd2); tick();
    chk("R2 R8 burst first", 1'b1, fill(8'h41));
    oe_n = 1'b1; #1;
    chk("R9 output blanked", 1'b0, '0);
    oe_n = 1'b0; #1;
    chk("R9 output restored", 1'b1, fill(8'h41));
    drv_cont(1'b1, 2'd3); tick();
    chk("R8 R7 continue ignores enables", 1'b1, fill(8'h42));
    drv_cont(1'b0, 2'd3); tick();
    chk("R8 suspend repeats", 1'b1, fill(8'h42));
    drv_desel(); tick();
    chk("R8 advance to low bits 3", 1'b1, fill(8'h43));
    tick();
    chk("R10 after burst", 1'b0, '0);

    // R11: after deselect, continue cycles with writes perform no access
    drv_cpu(8'h10); tick();
    drv_desel(); tick(); tick();
    drv_cont(1'b0, 2'd1); wall_n = 1'b0; wdata = '1; tick();
    drv_cont(1'b1, 2'd1); wall_n = 1'b0; wdata = '1; tick();
    chk("R11 no access after deselect", 1'b0, '0);
    drv_desel(); tick();
    chk("R11 still quiet", 1'b0, '0);
    read_chk("R11 word untouched", 8'h11);

    // R12 / R8: write burst with continue
    drv_ctl(8'h50, 1'b0, 1'b1, '1, 36'h3_1111_2222); tick();
    drv_cont(1'b0, 2'd1); wall_n = 1'b0; wdata = 36'h4_3333_4444;
    model[8'h51] = 36'h4_3333_4444; tick();
    chk("R12 write burst no output", 1'b0, '0);
    drv_desel(); tick();
    chk("R12 continue write no output", 1'b0, '0);
    read_chk("R12 burst write start", 8'h50);
    read_chk("R8 burst write continue", 8'h51);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule